// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block sits between a host bus and an external asynchronous read-only memory that supports a fast page mode. It takes read requests on a valid/ready handshake. Each request carries a byte address and a width select. The block drives the memory's word address, byte-lane address bit, width pin, chip select and output enable. It waits a fixed number of clock cycles, samples the memory data pins and returns the result on a valid/ready response channel.

The memory splits its space into pages of 2^PAGE_BITS words. While chip select stays asserted, a read that differs from the previous one only inside the page settles in the short page delay. A read that changes the page, changes the width, or starts with chip select just asserted needs the full access delay. The block remembers which page is open and selects the short or the long wait for each read. After IDLE_MAX cycles with no request it releases chip select, which closes the page. After each read it keeps the next address off the pins until the data pins have had T_FLOAT cycles to float.

Back-pressure: `req_ready` is high only when no read is in flight, no response is waiting and the float gap has elapsed. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` stays high with `rsp_data` unchanged until the edge where `rsp_ready` is high. No new request is taken while a response is pending.

Top module: `pgrom_rd_ctrl`

## Requirements
- R1: After reset, `rom_ce_n` and `rom_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read that is not a page hit is sampled exactly max(T_FULL, T_OE) cycles after its accept edge, so `rsp_valid` rises on that edge.
- R3: A page hit is a read taken while chip select is still low from an earlier read, with the same address bits above the page offset (byte-address bits ADDR_W down to PAGE_BITS+1) and the same width. A hit is sampled exactly max(T_PAGE, T_OE) cycles after its accept edge.
- R4: Word reads (`req_byte`=0) drive `rom_wide`=1, `rom_addr`=`req_addr[ADDR_W:1]`, and return all DATA_W data bits.
- R5: Byte reads (`req_byte`=1) drive `rom_wide`=0 and `rom_lsb`=`req_addr[0]`. They return the low DATA_W/2 data pins in the low half of `rsp_data` and zeros in the high half.
- R6: A change of width between two reads of the same page counts as a miss.
- R7: After `rom_oe_n` rises, `rom_addr` and `rom_lsb` do not change for T_FLOAT cycles.
- R8: After IDLE_MAX consecutive idle cycles with chip select low, `rom_ce_n` goes to 1, and the next read is a miss.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid` stays 1, `rsp_data` is stable and `req_ready` is 0.
- R10: `rom_oe_n` is 0 only while `rom_ce_n` is 0, and it is 1 whenever no read is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W+1 | Byte address; bit 0 selects the byte lane |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | DATA_W | Read result |
| rom_addr | output | ADDR_W | Memory word address |
| rom_lsb | output | 1 | Memory byte-lane address bit (byte mode) |
| rom_wide | output | 1 | Memory width select, 1 = word |
| rom_ce_n | output | 1 | Memory chip select, active low |
| rom_oe_n | output | 1 | Memory output enable, active low |
| rom_dq | input | DATA_W | Memory data pins |

## Verification
The assertions assume that `rom_dq` is only sampled as data, that `rsp_ready` may change freely, and that a request, once raised, keeps its address and width until it is taken. The bench drivers hold `req_valid`, `req_addr` and `req_byte` from the negative edge until the accepting edge and change nothing else in that time. A timing model of the memory in the bench returns a junk pattern until the full, page and output-enable delays have passed since the relevant pin changes. It also flags any address change that falls inside the float window, so an early sample or a missed gap shows up as a data mismatch or a float error. Idle gaps are kept well below or well above IDLE_MAX, so each read is either clearly a hit or clearly a miss.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } pgr_state_e;

  function automatic int unsigned pgr_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pgr_page_tracker.sv
module pgr_page_tracker #(
  parameter int TAG_W    = 15,
  parameter int IDLE_MAX = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             wide_in,
  input  logic             idle,
  output logic             hit,
  output logic             ce_n
);
  localparam int IDLE_W = $clog2(IDLE_MAX + 1);

  logic              open_q;
  logic [TAG_W-1:0]  tag_q;
  logic              wide_q;
  logic [IDLE_W-1:0] idle_cnt;
  logic              timeout;

  assign timeout = (idle_cnt == IDLE_W'(IDLE_MAX - 1));
  assign hit     = open_q && (tag_q == tag_in) && (wide_q == wide_in);
  assign ce_n    = ~open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      tag_q    <= '0;
      wide_q   <= 1'b1;
      idle_cnt <= '0;
    end else if (start) begin
      open_q   <= 1'b1;
      tag_q    <= tag_in;
      wide_q   <= wide_in;
      idle_cnt <= '0;
    end else if (idle && open_q) begin
      if (timeout) begin
        open_q   <= 1'b0;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  // R8
  page_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> ($past(idle_cnt) == IDLE_W'(IDLE_MAX - 1)) && $past(idle));

  // R8
  idle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt < IDLE_W'(IDLE_MAX));
endmodule

// File: rtl/pgr_wait_timer.sv
module pgr_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CNT_W'(1));

  // R2
  wait_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

  // R3
  wait_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> (cnt == '0));
endmodule

// File: rtl/pgr_float_guard.sv
module pgr_float_guard #(
  parameter int T_FLOAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic clear
);
  localparam int FL_W = $clog2(T_FLOAT + 2);

  logic [FL_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (trigger)   cnt <= FL_W'(T_FLOAT);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign clear = (cnt == '0);

  // R7
  float_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !trigger) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pgrom_rd_ctrl.sv
module pgrom_rd_ctrl
  import pgr_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int PAGE_BITS = 3,
  parameter int T_FULL    = 9,
  parameter int T_PAGE    = 5,
  parameter int T_OE      = 4,
  parameter int T_FLOAT   = 3,
  parameter int IDLE_MAX  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              req_byte,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_lsb,
  output logic              rom_wide,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  input  logic [DATA_W-1:0] rom_dq
);
  localparam int W_MISS = pgr_max(T_FULL, T_OE);
  localparam int W_HIT  = pgr_max(T_PAGE, T_OE);
  localparam int CNT_W  = $clog2(W_MISS + 1);
  localparam int TAG_W  = ADDR_W - PAGE_BITS;
  localparam int BYTE_W = DATA_W / 2;

  pgr_state_e        state;
  logic              accept;
  logic              trk_hit;
  logic              wait_done;
  logic              float_clear;
  logic              sample;
  logic [CNT_W-1:0]  wait_len;
  logic [TAG_W-1:0]  req_tag;
  logic [DATA_W-1:0] dq_fmt;

  assign req_tag   = req_addr[ADDR_W:PAGE_BITS+1];
  assign req_ready = (state == ST_IDLE) && float_clear;
  assign accept    = req_valid && req_ready;
  assign wait_len  = trk_hit ? CNT_W'(W_HIT) : CNT_W'(W_MISS);
  assign sample    = (state == ST_WAIT) && wait_done;
  assign rsp_valid = (state == ST_HOLD);

  pgr_page_tracker #(.TAG_W(TAG_W), .IDLE_MAX(IDLE_MAX)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .tag_in  (req_tag),
    .wide_in (~req_byte),
    .idle    ((state == ST_IDLE) && !accept),
    .hit     (trk_hit),
    .ce_n    (rom_ce_n)
  );

  pgr_wait_timer #(.CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (wait_len),
    .done     (wait_done)
  );

  pgr_float_guard #(.T_FLOAT(T_FLOAT)) u_flt (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (sample),
    .clear   (float_clear)
  );

  // byte reads keep only the low lane; the high pins float in that mode
  always_comb begin
    if (rom_wide) dq_fmt = rom_dq;
    else          dq_fmt = {{(DATA_W - BYTE_W){1'b0}}, rom_dq[BYTE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rom_addr <= '0;
      rom_lsb  <= 1'b0;
      rom_wide <= 1'b1;
      rom_oe_n <= 1'b1;
      rsp_data <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          rom_addr <= req_addr[ADDR_W:1];
          rom_lsb  <= req_byte & req_addr[0];
          rom_wide <= ~req_byte;
          rom_oe_n <= 1'b0;
          state    <= ST_WAIT;
        end
        ST_WAIT: if (wait_done) begin
          rsp_data <= dq_fmt;
          rom_oe_n <= 1'b1;
          state    <= ST_HOLD;
        end
        ST_HOLD: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  float_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !float_clear |=> ($stable(rom_addr) && $stable(rom_lsb)));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9
  no_accept_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R10
  oe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_ce_n);

  // R2
  drive_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!rom_ce_n && !rom_oe_n));

  // R10
  oe_off_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> rom_oe_n);
endmodule

// File: tb/sim_pgrom_rd_ctrl.sv
module sim_pgrom_rd_ctrl;
  localparam int CLK_P     = 10;
  localparam int ADDR_W    = 18;
  localparam int DATA_W    = 16;
  localparam int PAGE_BITS = 3;
  localparam int T_FULL    = 9;
  localparam int T_PAGE    = 5;
  localparam int T_OE      = 4;
  localparam int T_FLOAT   = 3;
  localparam int IDLE_MAX  = 20;
  localparam int LAT_MISS  = (T_FULL > T_OE) ? T_FULL : T_OE;
  localparam int LAT_HIT   = (T_PAGE > T_OE) ? T_PAGE : T_OE;

  typedef struct {
    logic [DATA_W-1:0] data;
    int                lat;
    int                acc;
    string             tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_byte = 1'b0, rsp_ready = 1'b1;
  logic [ADDR_W:0] req_addr = '0;
  logic req_ready, rsp_valid, rom_lsb, rom_wide, rom_ce_n, rom_oe_n;
  logic [DATA_W-1:0] rsp_data, rom_dq;
  logic [ADDR_W-1:0] rom_addr;

  int checks = 0, errors = 0, cyc = 0;
  bit seen = 1'b0;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pgrom_rd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .T_FULL(T_FULL),
    .T_PAGE(T_PAGE), .T_OE(T_OE), .T_FLOAT(T_FLOAT), .IDLE_MAX(IDLE_MAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rom_addr(rom_addr),
    .rom_lsb(rom_lsb), .rom_wide(rom_wide), .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n), .rom_dq(rom_dq)
  );

  function automatic logic [DATA_W-1:0] rom_word(input logic [ADDR_W-1:0] w);
    int unsigned v;
    v = (32'(w) * 32'd40503) ^ (32'(w) >> 3) ^ 32'h1234;
    return v[DATA_W-1:0];
  endfunction

  // ---- memory timing model ----
  logic [ADDR_W-1:0] m_addr = '0;
  logic m_lsb = 1'b0, m_wide = 1'b1, m_ce_n = 1'b1, m_oe_n = 1'b1;
  int full_age = 0, page_age = 0, oe_age = 0, fl_age = 1000;
  logic m_ok;

  always @(negedge clk) begin
    if (rom_ce_n || m_ce_n ||
        rom_addr[ADDR_W-1:PAGE_BITS] != m_addr[ADDR_W-1:PAGE_BITS] || rom_wide != m_wide)
      full_age <= 0;
    else full_age <= full_age + 1;
    if (rom_addr != m_addr || rom_lsb != m_lsb) page_age <= 0;
    else page_age <= page_age + 1;
    if (rom_oe_n || m_oe_n) oe_age <= 0;
    else oe_age <= oe_age + 1;
    if (rom_addr != m_addr || rom_lsb != m_lsb) begin
      if (fl_age < T_FLOAT) begin
        errors <= errors + 1;
        $display("FAIL R7: address moved %0d cycles after output enable release, expected >= %0d",
                 fl_age, T_FLOAT);
      end
    end
    if (rom_oe_n && !m_oe_n) fl_age <= 0;
    else if (fl_age < 1000) fl_age <= fl_age + 1;
    m_addr <= rom_addr; m_lsb <= rom_lsb; m_wide <= rom_wide;
    m_ce_n <= rom_ce_n; m_oe_n <= rom_oe_n;
  end

  assign m_ok = !m_ce_n && !m_oe_n && full_age >= T_FULL - 1 &&
                page_age >= T_PAGE - 1 && oe_age >= T_OE - 1;

  always_comb begin
    if (!m_ok)       rom_dq = 16'hDEAD;
    else if (m_wide) rom_dq = rom_word(m_addr);
    else if (m_lsb)  rom_dq = {8'hA5, rom_word(m_addr)[15:8]};
    else             rom_dq = {8'hA5, rom_word(m_addr)[7:0]};
  end

  // ---- scoreboard ----
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [ADDR_W:0] a, input bit byt, input bit hit, input string tag);
    exp_t e;
    logic [DATA_W-1:0] w;
    w = rom_word(a[ADDR_W:1]);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_byte = byt;
    while (!req_ready) @(negedge clk);
    e.acc  = cyc + 1;
    e.lat  = hit ? LAT_HIT : LAT_MISS;
    e.data = !byt ? w : (a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]});
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain;
    while (q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected response %0h, expected none", rsp_data);
      end else begin
        if (!seen) begin
          seen = 1'b1;
          chk(cyc - q[0].acc == q[0].lat, {q[0].tag, " latency"}, cyc - q[0].acc, q[0].lat);
        end
        if (rsp_ready) begin
          chk(rsp_data == q[0].data, {q[0].tag, " data"}, rsp_data, q[0].data);
          void'(q.pop_front());
          seen = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rom_ce_n == 1'b1, "R1 ce_n", rom_ce_n, 1);
    chk(rom_oe_n == 1'b1, "R1 oe_n", rom_oe_n, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);

    // R2 / R4: first word read is a miss; R3: same-page words hit
    send({18'h00100, 1'b0}, 1'b0, 1'b0, "R2 word miss");
    send({18'h00103, 1'b0}, 1'b0, 1'b1, "R3 word hit");
    send({18'h00107, 1'b0}, 1'b0, 1'b1, "R3 word hit");
    send({18'h00100, 1'b1}, 1'b0, 1'b1, "R4 word hit lsb ignored");
    send({18'h00108, 1'b0}, 1'b0, 1'b0, "R2 new page miss");
    // R6 width change is a miss; R5 byte lanes
    send({18'h00108, 1'b1}, 1'b1, 1'b0, "R6 width change miss");
    send({18'h0010F, 1'b0}, 1'b1, 1'b1, "R5 byte low hit");
    send({18'h0010A, 1'b1}, 1'b1, 1'b1, "R5 byte high hit");
    drain();

    // R9 back-pressure
    rsp_ready = 1'b0;
    send({18'h00109, 1'b0}, 1'b1, 1'b1, "R9 held byte hit");
    while (!rsp_valid) @(negedge clk);
    begin
      logic [DATA_W-1:0] held;
      held = rsp_data;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_data == held && !req_ready, "R9 hold", rsp_data, held);
      end
    end
    rsp_ready = 1'b1;
    drain();

    send({18'h00108, 1'b0}, 1'b0, 1'b0, "R6 back to word miss");
    drain();
    @(negedge clk);
    chk(rom_oe_n == 1'b1, "R10 oe_n idle", rom_oe_n, 1);
    chk(rom_ce_n == 1'b0, "R8 page still open", rom_ce_n, 0);

    // R8 idle timeout closes the page
    repeat (IDLE_MAX + 10) @(negedge clk);
    chk(rom_ce_n == 1'b1, "R8 ce_n after timeout", rom_ce_n, 1);
    chk(rom_oe_n == 1'b1, "R10 oe_n after timeout", rom_oe_n, 1);
    send({18'h0010C, 1'b0}, 1'b0, 1'b0, "R8 reopen miss");
    send({18'h3FFFF, 1'b0}, 1'b0, 1'b0, "R2 top page miss");
    send({18'h3FFF8, 1'b1}, 1'b1, 1'b0, "R6 top byte miss");
    send({18'h3FFFB, 1'b0}, 1'b1, 1'b1, "R5 top byte hit");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule